// File: doc/BRIEF.md
# Segmented Page Table Address Translator

This block turns a virtual address into a physical address with a mix of segmentation and paging. The upper bits of the virtual address choose one of three segments: code, heap or stack. Each segment has one register that holds the physical address of its own linear page table, and one register that holds the highest page number the segment may use. A page number above that limit never reaches memory, so the gap between heap and stack needs no table space at all.

For a legal page, the block reads one 4-byte table entry from memory through a valid/ready request channel and waits for a valid response. It checks the entry's valid bit and then builds the physical address from the frame number and the page offset. Only one translation is in flight at a time. With the default parameters the virtual space is 16 KB, split into 1 KB pages, and each segment holds up to four pages.

Top module: `seg_pt_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, and resp_valid_o and mem_req_valid_o are 0.
- R2: A virtual address whose two top bits are 00 gets a fault response in the cycle after it is accepted, and no memory read is issued.
- R3: Segment codes are 01 = code, 10 = heap and 11 = stack. The same codes select a register pair on reg_sel_i, and a write with reg_sel_i = 00 changes nothing. reg_bound_i = 1 writes the page limit, which is the low page-number bits of reg_wdata_i. reg_bound_i = 0 writes the table base.
- R4: For a legal page, mem_req_addr_o equals the selected base plus four times the in-segment page number. The in-segment page number is the virtual address bits just above the page offset.
- R5: An in-segment page number greater than the segment's limit gets a fault response in the cycle after acceptance, and no memory read is issued. A page number equal to the limit is translated.
- R6: The entry's top bit is its valid bit and its low bits are the frame number. When the entry is valid, resp_pa_o = {frame, page offset} and resp_fault_o = 0.
- R7: An entry with its valid bit clear produces resp_fault_o = 1 with resp_pa_o = 0. Every fault response has resp_pa_o = 0.
- R8: req_ready_o falls after a request is accepted and rises again only after the response cycle. mem_req_valid_o is never high while req_ready_o is high.
- R9: mem_req_valid_o stays high, with mem_req_addr_o unchanged, until mem_req_ready_i is seen. It then drops.
- R10: resp_valid_o is high for exactly one cycle per translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Segment code of the register pair to write |
| reg_bound_i | input | 1 | 1 = write the limit, 0 = write the table base |
| reg_wdata_i | input | PA_W | Write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Ready for a new request |
| req_va_i | input | VA_W | Virtual address |
| mem_req_valid_o | output | 1 | Table entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | PA_W | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | PTE_W | Table entry: valid bit on top, frame below |
| resp_valid_o | output | 1 | Translation result valid, one cycle |
| resp_fault_o | output | 1 | Translation faulted |
| resp_pa_o | output | PA_W | Physical address (0 on fault) |

## Verification
The bench probes the limit at both sides: a page equal to the limit must be fetched, and the next page up must fault without any memory traffic. A design that is off by one would either reject the last legal page or read an entry from outside the table. It also sends segment code 00 and an entry with its valid bit clear. A design that mishandles these would return a stale or partial physical address instead of a clean fault. Back-pressure on the memory request checks that the address is held steady, because a design that drops or changes it would fetch the wrong entry. Rewriting a segment's base and limit, and writing with select 00, shows whether the register decode routes writes to the right pair.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [1:0] {
    SEG_NONE  = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_HEAP  = 2'b10,
    SEG_STACK = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/spx_seg_regs.sv
module spx_seg_regs #(
  parameter int PA_W = 20,
  parameter int PN_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      sel_i,
  input  logic            bound_i,
  input  logic [PA_W-1:0] wdata_i,
  input  logic [1:0]      rd_sel_i,
  output logic [PA_W-1:0] base_o,
  output logic [PN_W-1:0] bound_o
);
  logic [PA_W-1:0] base_q  [4];
  logic [PN_W-1:0] bound_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_pair
    if (g == 0) begin : g_none
      // code 00 has no pair
      assign base_q[g]  = '0;
      assign bound_q[g] = '0;
    end else begin : g_seg
      logic hit;
      assign hit = we_i && (sel_i == 2'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q[g]  <= '0;
          bound_q[g] <= '0;
        end else if (hit) begin
          if (bound_i) bound_q[g] <= wdata_i[PN_W-1:0];
          else         base_q[g]  <= wdata_i;
        end
      end
    end
  end

  assign base_o  = base_q[rd_sel_i];
  assign bound_o = bound_q[rd_sel_i];
endmodule

// File: rtl/spx_index_check.sv
module spx_index_check
  import spx_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int PAGE_W = 10,
  parameter int PA_W   = 20
) (
  input  logic [VA_W-1:0]        va_i,
  input  logic [PA_W-1:0]        base_i,
  input  logic [VA_W-PAGE_W-3:0] bound_i,
  output seg_e                   seg_o,
  output logic                   fault_o,
  output logic [PA_W-1:0]        pte_addr_o,
  output logic [PAGE_W-1:0]      off_o
);
  localparam int PN_W = VA_W - PAGE_W - 2;

  logic [PN_W-1:0] pn;

  assign seg_o = seg_e'(va_i[VA_W-1 -: 2]);
  assign pn    = va_i[PAGE_W +: PN_W];
  assign off_o = va_i[PAGE_W-1:0];

  assign fault_o    = (seg_o == SEG_NONE) || (pn > bound_i);
  // 4-byte entries
  assign pte_addr_o = base_i + (PA_W'(pn) << 2);
endmodule

// File: rtl/spx_walk_ctrl.sv
module spx_walk_ctrl
  import spx_pkg::*;
#(
  parameter int PA_W   = 20,
  parameter int PAGE_W = 10,
  parameter int PTE_W  = PA_W - PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              early_fault_i,
  input  logic [PA_W-1:0]   pte_addr_i,
  input  logic [PAGE_W-1:0] off_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [PA_W-1:0]   resp_pa_o
);
  localparam int PFN_W = PA_W - PAGE_W;

  walk_st_e          st_q, st_d;
  logic [PA_W-1:0]   addr_q;
  logic [PAGE_W-1:0] off_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              fault_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = early_fault_i ? ST_DONE : ST_FETCH;
      ST_FETCH: if (mem_req_ready_i) st_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      pfn_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        addr_q  <= pte_addr_i;
        off_q   <= off_i;
        pfn_q   <= '0;
        fault_q <= early_fault_i;
      end
      if (st_q == ST_WAIT && mem_rsp_valid_i) begin
        fault_q <= ~mem_rsp_data_i[PTE_W-1];
        pfn_q   <= mem_rsp_data_i[PFN_W-1:0];
      end
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_FETCH);
  assign mem_req_addr_o  = addr_q;
  assign resp_valid_o    = (st_q == ST_DONE);
  assign resp_fault_o    = (st_q == ST_DONE) && fault_q;
  assign resp_pa_o       = (st_q == ST_DONE && !fault_q) ? {pfn_q, off_q} : '0;
endmodule

// File: rtl/seg_pt_xlate.sv
module seg_pt_xlate
  import spx_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int PAGE_W = 10,
  parameter int PA_W   = 20,
  parameter int PTE_W  = PA_W - PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_bound_i,
  input  logic [PA_W-1:0]   reg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [PA_W-1:0]   resp_pa_o
);
  localparam int PN_W = VA_W - PAGE_W - 2;

  seg_e              seg;
  logic [PA_W-1:0]   base;
  logic [PN_W-1:0]   bound;
  logic              early_fault;
  logic [PA_W-1:0]   pte_addr;
  logic [PAGE_W-1:0] off;

  spx_seg_regs #(.PA_W(PA_W), .PN_W(PN_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .bound_i  (reg_bound_i),
    .wdata_i  (reg_wdata_i),
    .rd_sel_i (seg),
    .base_o   (base),
    .bound_o  (bound)
  );

  spx_index_check #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PA_W(PA_W)) u_chk_idx (
    .va_i       (req_va_i),
    .base_i     (base),
    .bound_i    (bound),
    .seg_o      (seg),
    .fault_o    (early_fault),
    .pte_addr_o (pte_addr),
    .off_o      (off)
  );

  spx_walk_ctrl #(.PA_W(PA_W), .PAGE_W(PAGE_W), .PTE_W(PTE_W)) u_walk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .early_fault_i   (early_fault),
    .pte_addr_i      (pte_addr),
    .off_i           (off),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .resp_valid_o    (resp_valid_o),
    .resp_fault_o    (resp_fault_o),
    .resp_pa_o       (resp_pa_o)
  );
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
  parameter int VA_W = 14,
  parameter int PA_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o,
  input logic            resp_valid_o,
  input logic            resp_fault_o,
  input logic [PA_W-1:0] resp_pa_o
);
  AST_SEG_NONE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_va_i[VA_W-1 -: 2] == 2'b00
    |=> resp_valid_o && resp_fault_o && !mem_req_valid_o); // R2

  AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_valid_o && resp_pa_o == '0); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R8

  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o); // R8

  AST_MEMREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i
    |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R9

  AST_MEMREQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o); // R9

  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && req_ready_o); // R10
endmodule

bind seg_pt_xlate spx_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_spx_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_va_i        (req_va_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .resp_valid_o    (resp_valid_o),
  .resp_fault_o    (resp_fault_o),
  .resp_pa_o       (resp_pa_o)
);

// File: tb/tb_seg_pt_xlate.sv
`timescale 1ns/1ps
module tb_seg_pt_xlate;
  localparam int VA_W   = 14;
  localparam int PAGE_W = 10;
  localparam int PA_W   = 20;
  localparam int PTE_W  = PA_W - PAGE_W + 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [1:0]       reg_sel_i = '0;
  logic             reg_bound_i = 1'b0;
  logic [PA_W-1:0]  reg_wdata_i = '0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [VA_W-1:0]  req_va_i = '0;
  logic             mem_req_valid_o;
  logic             mem_req_ready_i = 1'b0;
  logic [PA_W-1:0]  mem_req_addr_o;
  logic             mem_rsp_valid_i = 1'b0;
  logic [PTE_W-1:0] mem_rsp_data_i = '0;
  logic             resp_valid_o;
  logic             resp_fault_o;
  logic [PA_W-1:0]  resp_pa_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  seg_pt_xlate #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PA_W(PA_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic bnd, input logic [PA_W-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_bound_i = bnd; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // one translation; exp_mem selects the table-read path
  task automatic xlate(input string tag, input logic [VA_W-1:0] va, input bit exp_mem,
                       input logic [PA_W-1:0] exp_addr, input logic [PTE_W-1:0] pte,
                       input int hold, input bit exp_fault, input logic [PA_W-1:0] exp_pa);
    @(negedge clk_i);
    chk(req_ready_o, {tag, " R8 ready idle"}, req_ready_o, 1);
    req_valid_i = 1'b1; req_va_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!req_ready_o, {tag, " R8 busy"}, req_ready_o, 0);
    if (exp_mem) begin
      chk(mem_req_valid_o && !resp_valid_o, {tag, " R5 read issued"}, mem_req_valid_o, 1);
      chk(mem_req_addr_o == exp_addr, {tag, " R4 pte addr"}, mem_req_addr_o, exp_addr);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk_i);
        chk(mem_req_valid_o && mem_req_addr_o == exp_addr, {tag, " R9 hold"},
            mem_req_addr_o, exp_addr);
      end
      mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      chk(!mem_req_valid_o, {tag, " R9 drop"}, mem_req_valid_o, 0);
      mem_rsp_valid_i = 1'b1; mem_rsp_data_i = pte;
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
    end else begin
      chk(!mem_req_valid_o, {tag, " R2/R5 no read"}, mem_req_valid_o, 0);
    end
    chk(resp_valid_o, {tag, " R10 resp"}, resp_valid_o, 1);
    chk(resp_fault_o == exp_fault, {tag, " R6/R7 fault"}, resp_fault_o, exp_fault);
    chk(resp_pa_o == exp_pa, {tag, " R6/R7 pa"}, resp_pa_o, exp_pa);
    @(negedge clk_i);
    chk(!resp_valid_o && req_ready_o, {tag, " R10 pulse"}, resp_valid_o, 0);
  endtask

  task automatic t_reset();
    chk(req_ready_o && !resp_valid_o && !mem_req_valid_o, "R1 reset",
        {req_ready_o, resp_valid_o, mem_req_valid_o}, 3'b100);
  endtask

  task automatic t_setup();
    wr_reg(2'b01, 1'b0, 20'h01000);
    wr_reg(2'b01, 1'b1, 20'h00001);
    wr_reg(2'b10, 1'b0, 20'h02000);
    wr_reg(2'b10, 1'b1, 20'h00003);
    wr_reg(2'b11, 1'b0, 20'h03000);
    wr_reg(2'b11, 1'b1, 20'h00000);
    wr_reg(2'b00, 1'b0, 20'h0F000); // R3 select 00 ignored
  endtask

  task automatic t_code();
    xlate("R3 code pg1", 14'h16A5, 1, 20'h01004, 11'h523, 0, 0, 20'h48EA5);
    xlate("R5 code over", 14'h1800, 0, '0, '0, 0, 1, '0);
  endtask

  task automatic t_heap();
    xlate("R5 heap at limit", 14'h2FFF, 1, 20'h0200C, 11'h7FF, 3, 0, 20'hFFFFF);
    xlate("R7 heap invalid", 14'h2010, 1, 20'h02000, 11'h055, 1, 1, '0);
  endtask

  task automatic t_seg_none();
    xlate("R2 seg 00", 14'h0123, 0, '0, '0, 0, 1, '0);
  endtask

  task automatic t_stack();
    xlate("R6 stack pg0", 14'h3001, 1, 20'h03000, 11'h401, 0, 0, 20'h00401);
    xlate("R5 stack over", 14'h3400, 0, '0, '0, 0, 1, '0);
    wr_reg(2'b11, 1'b0, 20'h04000);
    wr_reg(2'b11, 1'b1, 20'h00003);
    xlate("R3 stack rewrite", 14'h3C00, 1, 20'h0400C, 11'h600, 2, 0, 20'h80000);
    xlate("R3 code kept", 14'h1400, 1, 20'h01004, 11'h40A, 0, 0, 20'h02800);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_setup();
    t_code();
    t_heap();
    t_seg_none();
    t_stack();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule